// File: doc/BRIEF.md
# Shared-Bus Priority Arbiter

This block sits between one processor's local bus and a bus shared by several masters. When the local master needs the shared bus, the arbiter raises a request. It takes ownership only when it holds priority from the master above it in a daisy chain and no other master reports the bus as busy. While it owns the bus it drives the common busy line and enables the local master's drivers onto the shared bus. Priority passes down the chain to lower masters only while this master neither wants nor holds the bus.

All masters run from one common bus clock, and every state change and output change happens on a falling edge of that clock. When the local master finishes a cycle, the arbiter keeps the bus in a parked state, which avoids a new arbitration for the next local cycle. It gives the bus up at once when higher-priority demand removes its priority-in, or when a lower-priority master signals on the common request line. The block has no data path: every pin is a plain level-sensitive control line, so no valid/ready handshake or back-pressure applies.

Top module: `shbus_arbiter`

## Requirements
- R1: While `rst_n` is low, all outputs (`breq`, `busy_out`, `bus_en`, `cbrq_out`, `prio_out`) are 0.
- R2: Outputs change only on falling edges of `bclk` (or on reset assertion), never in the high phase of the clock.
- R3: An idle arbiter that samples `loc_req`=1 on a falling edge raises `breq` after that edge and, until it owns the bus, holds `cbrq_out`=1.
- R4: A waiting arbiter acquires the bus on a falling edge only if `prio_in`=1 and `busy_in`=0 at that same edge. Acquisition raises `busy_out` and `bus_en` together.
- R5: While `busy_in`=1, a waiting arbiter does not acquire the bus, whatever the state of `prio_in`.
- R6: `prio_out` equals `prio_in` sampled at the last falling edge when the arbiter ends that edge idle, and is 0 whenever `breq` is 1.
- R7: If `loc_req` is 0 at a falling edge while the arbiter is still waiting, it returns to idle and `breq` and `cbrq_out` fall.
- R8: An owner that samples `loc_done`=1 together with `prio_in`=0 releases the bus: `busy_out`, `bus_en` and `breq` fall after that edge.
- R9: An owner that samples `loc_done`=1 together with `cbrq_in`=1 releases the bus in the same way.
- R10: An owner that samples `loc_done`=1 with `prio_in`=1 and `cbrq_in`=0 parks: `busy_out` and `breq` stay 1 and `bus_en` falls.
- R11: A parked arbiter that samples `loc_req`=1, with priority kept and no common request, raises `bus_en` again after that edge and never lowers `busy_out` in between.
- R12: A parked arbiter releases the bus after any falling edge at which `prio_in`=0 or `cbrq_in`=1, even when `loc_req`=1 at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Common bus clock; all state is updated on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_req | input | 1 | Local master needs the shared bus |
| loc_done | input | 1 | Local master has ended its current shared-bus cycle |
| prio_in | input | 1 | Priority granted from the next-higher master in the chain |
| busy_in | input | 1 | Another master currently holds the shared bus |
| cbrq_in | input | 1 | A lower-priority master is waiting for the shared bus |
| breq | output | 1 | This master requests or holds the shared bus |
| busy_out | output | 1 | This master drives the shared busy line |
| bus_en | output | 1 | Enables the local master's drivers onto the shared bus |
| cbrq_out | output | 1 | Contributes to the common request line while waiting |
| prio_out | output | 1 | Priority passed on to the next-lower master |

## Verification
The parked state is the hardest to reach and to leave in a controlled way. It exists only after a full request, grant and done sequence with priority still held and the common request quiet. Each of its exits (a local re-request, loss of priority, or a lower-priority request) needs that setup to be rebuilt first. The stimulus walks the arbiter through acquire-then-park several times and applies one exit condition each time. It also combines a local re-request with a release condition in the same cycle, which shows that release takes precedence. A behavioural model in the bench is checked twice in every high phase, so any output change outside a falling edge is reported.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_WAIT = 2'd1,
    ARB_OWN  = 2'd2,
    ARB_PARK = 2'd3
  } arb_state_e;
endpackage

// File: rtl/shbus_fsm.sv
module shbus_fsm
  import shbus_pkg::*;
#(
  parameter int PARK_EN = 1
) (
  input  logic       bclk,
  input  logic       rst_n,
  input  logic       loc_req,
  input  logic       loc_done,
  input  logic       prio_in,
  input  logic       busy_in,
  input  logic       cbrq_in,
  output arb_state_e state_q,
  output arb_state_e state_d
);
  logic must_yield;
  logic may_keep;

  // Release is forced whenever priority is lost or a lower master waits.
  assign must_yield = !prio_in || cbrq_in;

  generate
    if (PARK_EN != 0) begin : g_park
      assign may_keep = !must_yield;
    end else begin : g_nopark
      assign may_keep = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: if (loc_req) state_d = ARB_WAIT;
      ARB_WAIT: begin
        if (!loc_req)                  state_d = ARB_IDLE;
        else if (prio_in && !busy_in)  state_d = ARB_OWN;
      end
      ARB_OWN: begin
        if (loc_done) state_d = may_keep ? ARB_PARK : ARB_IDLE;
      end
      ARB_PARK: begin
        if (must_yield)   state_d = ARB_IDLE;
        else if (loc_req) state_d = ARB_OWN;
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/shbus_chain.sv
module shbus_chain
  import shbus_pkg::*;
(
  input  logic       bclk,
  input  logic       rst_n,
  input  logic       prio_in,
  input  arb_state_e state_d,
  output logic       prio_out
);
  // Priority passes down only while this master ends the edge idle.
  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) prio_out <= 1'b0;
    else        prio_out <= prio_in && (state_d == ARB_IDLE);
  end
endmodule

// File: rtl/shbus_outdec.sv
module shbus_outdec
  import shbus_pkg::*;
(
  input  arb_state_e state_q,
  output logic       breq,
  output logic       busy_out,
  output logic       bus_en,
  output logic       cbrq_out
);
  always_comb begin
    breq     = (state_q != ARB_IDLE);
    busy_out = (state_q == ARB_OWN) || (state_q == ARB_PARK);
    bus_en   = (state_q == ARB_OWN);
    cbrq_out = (state_q == ARB_WAIT);
  end
endmodule

// File: rtl/shbus_arbiter.sv
module shbus_arbiter
  import shbus_pkg::*;
#(
  parameter int PARK_EN = 1
) (
  input  logic bclk,
  input  logic rst_n,
  input  logic loc_req,
  input  logic loc_done,
  input  logic prio_in,
  input  logic busy_in,
  input  logic cbrq_in,
  output logic breq,
  output logic busy_out,
  output logic bus_en,
  output logic cbrq_out,
  output logic prio_out
);
  arb_state_e st_q;
  arb_state_e st_d;

  shbus_fsm #(.PARK_EN(PARK_EN)) u_fsm (
    .bclk(bclk), .rst_n(rst_n), .loc_req(loc_req), .loc_done(loc_done),
    .prio_in(prio_in), .busy_in(busy_in), .cbrq_in(cbrq_in),
    .state_q(st_q), .state_d(st_d)
  );

  shbus_chain u_chain (
    .bclk(bclk), .rst_n(rst_n), .prio_in(prio_in),
    .state_d(st_d), .prio_out(prio_out)
  );

  shbus_outdec u_dec (
    .state_q(st_q), .breq(breq), .busy_out(busy_out),
    .bus_en(bus_en), .cbrq_out(cbrq_out)
  );
endmodule

// File: rtl/shbus_arbiter_chk.sv
module shbus_arbiter_chk #(
  parameter int PARK_EN = 1
) (
  input logic bclk,
  input logic rst_n,
  input logic loc_req,
  input logic loc_done,
  input logic prio_in,
  input logic busy_in,
  input logic cbrq_in,
  input logic breq,
  input logic busy_out,
  input logic bus_en,
  input logic cbrq_out,
  input logic prio_out
);
  assert_grant_cond_R4: assert property (@(negedge bclk) disable iff (!rst_n)
    $rose(busy_out) |-> ($past(prio_in) && !$past(busy_in) && $past(breq)));

  assert_enable_pair_R4: assert property (@(negedge bclk) disable iff (!rst_n)
    $rose(busy_out) |-> bus_en);

  assert_wait_flag_R3: assert property (@(negedge bclk) disable iff (!rst_n)
    cbrq_out |-> (breq && !busy_out));

  assert_chain_block_R6: assert property (@(negedge bclk) disable iff (!rst_n)
    breq |-> !prio_out);

  assert_park_busy_R10: assert property (@(negedge bclk) disable iff (!rst_n)
    bus_en |-> (busy_out && breq));

  assert_release_cause_R8: assert property (@(negedge bclk) disable iff (!rst_n)
    ($fell(busy_out) && (PARK_EN != 0)) |-> ($past(!prio_in) || $past(cbrq_in)));

  assert_busy_block_R5: assert property (@(negedge bclk) disable iff (!rst_n)
    ($past(busy_in) && $past(cbrq_out)) |-> !busy_out);

  assert_unused_inputs_R7: assert property (@(negedge bclk) disable iff (!rst_n)
    ($past(cbrq_out) && !$past(loc_req)) |-> !breq);

  logic unused_ok;
  assign unused_ok = loc_done;
endmodule

bind shbus_arbiter shbus_arbiter_chk #(.PARK_EN(PARK_EN)) u_chk (.*);

// File: tb/tb_shbus_arbiter.sv
`timescale 1ns/1ps
module tb_shbus_arbiter;
  logic bclk = 1'b0;
  logic rst_n = 1'b0;
  logic loc_req = 1'b0, loc_done = 1'b0, prio_in = 1'b0;
  logic busy_in = 1'b0, cbrq_in = 1'b0;
  logic breq, busy_out, bus_en, cbrq_out, prio_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string phase = "R1";

  // Behavioural reference: three flags describe ownership.
  bit m_req = 0, m_own = 0, m_park = 0, m_po = 0;

  always #10 bclk = ~bclk;

  shbus_arbiter dut (
    .bclk(bclk), .rst_n(rst_n), .loc_req(loc_req), .loc_done(loc_done),
    .prio_in(prio_in), .busy_in(busy_in), .cbrq_in(cbrq_in),
    .breq(breq), .busy_out(busy_out), .bus_en(bus_en),
    .cbrq_out(cbrq_out), .prio_out(prio_out)
  );

  always @(negedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_own = 0; m_park = 0; m_po = 0;
    end else begin
      if (!m_req) begin
        if (loc_req) m_req = 1;
      end else if (!m_own) begin
        if (!loc_req) m_req = 0;
        else if (prio_in && !busy_in) m_own = 1;
      end else if (!m_park) begin
        if (loc_done) begin
          if (!prio_in || cbrq_in) begin m_req = 0; m_own = 0; end
          else m_park = 1;
        end
      end else begin
        if (!prio_in || cbrq_in) begin m_req = 0; m_own = 0; m_park = 0; end
        else if (loc_req) m_park = 0;
      end
      m_po = prio_in && !m_req;
    end
  end

  task automatic cmp(input string tag);
    logic [4:0] act, exp;
    act = {breq, busy_out, bus_en, cbrq_out, prio_out};
    exp = {m_req, m_own, m_own && !m_park, m_req && !m_own, m_po};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t {breq,busy,en,cbrq,po} actual=%b expected=%b",
               tag, $time, act, exp);
    end
  endtask

  // Two samples per high phase; the late one guards R2.
  always @(posedge bclk) begin
    cycles++;
    #2 cmp(phase);
    #7 cmp("R2");
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge bclk);
      #1;
    end
  endtask

  task automatic acquire();
    prio_in = 1; busy_in = 0; cbrq_in = 0; loc_done = 0; loc_req = 1;
    step(3);
  endtask

  task automatic done_pulse(input bit p, input bit c);
    loc_req = 0; loc_done = 1; prio_in = p; cbrq_in = c;
    step(1);
    loc_done = 0;
  endtask

  initial begin
    phase = "R1"; step(3);
    rst_n = 1;
    phase = "R6"; prio_in = 1; step(3);
    prio_in = 0; step(2);
    prio_in = 1; step(2);
    phase = "R3"; busy_in = 1; loc_req = 1; step(2);
    phase = "R5"; step(3);
    phase = "R7"; loc_req = 0; step(2);
    phase = "R4"; prio_in = 0; busy_in = 0; loc_req = 1; step(3);
    prio_in = 1; step(3);
    phase = "R8"; done_pulse(0, 0); step(2);
    phase = "R9"; acquire(); done_pulse(1, 1); cbrq_in = 0; step(2);
    phase = "R10"; acquire(); done_pulse(1, 0); step(3);
    phase = "R11"; loc_req = 1; step(2);
    done_pulse(1, 0); step(2);
    phase = "R12"; loc_req = 1; cbrq_in = 1; step(1);
    loc_req = 0; cbrq_in = 0; step(1);
    acquire(); done_pulse(1, 0); step(1);
    prio_in = 0; step(2);
    prio_in = 1; step(2);
    phase = "R6"; step(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    fails++;
    $display("FAIL watchdog expired actual=%0d cycles expected=<5000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule